// File: doc/BRIEF.md
# Guarded Dual-Channel Table-to-DAC Register Bank

This block is the byte-wide register file of a two-channel, table-driven DAC controller. A simple parallel bus reaches it with an address, write data, a write strobe, a read strobe, registered read data and a registered write acknowledge. Two 64-entry lookup tables live inside the block, each mapped into its own window of the address space. Each channel has a routing byte that chooses two things. The first is the table index, which is either the live 6-bit ADC code or a direct index that software programs. The second is the value sent to the DAC, which is either the indexed table entry or a raw code that software programs.

Every write is guarded by a volatile write-enable flag. The flag is armed or disarmed only by writing one exact byte to its own address. While the flag is down, no other location can be changed, and such writes get no acknowledge. A read-only status address returns the ADC code. Reads are allowed at any time.

Top module: `lutdac_regbank`

## Requirements
- R1: After reset the write-enable flag is clear, the routing byte at 0x80 reads 0x00 (both channels use the ADC code as table index and the table entry as DAC source), and the direct-index and raw-code registers read 0x00.
- R2: Writing 0x80 to address 0x86 sets the write-enable flag and writing 0x00 clears it. Reading 0x86 returns the flag in bit 7 with bits 6..0 always 0. The flag changes in no other way except by reset.
- R3: While the flag is clear, a write to any address other than 0x86 changes nothing (registers, tables and DAC codes) and is not acknowledged.
- R4: A write to 0x86 of any value other than 0x80 or 0x00 leaves the flag unchanged and is still acknowledged.
- R5: Address 0x87 reads as {2'b00, adc_code}. Writes to it change nothing.
- R6: `wr_ack` is high in the cycle after an accepted write and is low otherwise. A write is accepted when it targets 0x86 or the flag is set. `rd_data` carries the value addressed by a `rd` strobe in the cycle after that strobe.
- R7: Addresses 0x00–0x3F hold table 1 entries 0–63 and addresses 0x40–0x7F hold table 2 entries 0–63, 8 bits each, readable and writable over the bus.
- R8: Routing byte bit 0 selects the table-1 index: 0 uses adc_code, 1 uses bits 5..0 of register 0x81. Reading 0x81 returns those 6 bits with bits 7..6 as 0.
- R9: Routing byte bit 1 selects the DAC-1 source: 0 uses the indexed table-1 entry, 1 uses register 0x83.
- R10: Routing byte bits 2 and 3 do the same for channel 2: bit 2 selects the direct index in 0x82 for table 2, and bit 3 selects the raw code in 0x84 for DAC 2.
- R11: Each DAC code is registered. It reflects a change of its source (ADC code, table entry, routing, direct index or raw code) one clock edge after the edge or cycle where the change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Bus address |
| wr_data | input | 8 | Bus write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data |
| wr_ack | output | 1 | Registered write acknowledge |
| adc_code | input | 6 | Current ADC conversion result |
| dac1_code | output | 8 | Channel 1 DAC input code |
| dac2_code | output | 8 | Channel 2 DAC input code |

## Verification
The assertions assume that `addr` and `wr_data` are stable and known whenever `wr` is high, and that `adc_code` is a known value once reset has been released. The bench drives every bus signal on the falling clock edge and holds `wr` and `rd` for exactly one cycle. It changes `adc_code` only between bus operations. It writes every table entry before it compares a DAC code against a table-derived value, so it never depends on memory contents that were never written.

// File: rtl/lutdac_pkg.sv
package lutdac_pkg;

  localparam logic [7:0] ADDR_ROUTE = 8'h80;
  localparam logic [7:0] ADDR_DIR0  = 8'h81;  // channel n uses ADDR_DIR0 + n
  localparam logic [7:0] ADDR_RAW0  = 8'h83;  // channel n uses ADDR_RAW0 + n
  localparam logic [7:0] ADDR_WEN   = 8'h86;
  localparam logic [7:0] ADDR_STAT  = 8'h87;

  localparam logic [7:0] WEN_ARM    = 8'h80;
  localparam logic [7:0] WEN_DISARM = 8'h00;

  typedef enum logic [1:0] {
    RSRC_REG  = 2'd0,
    RSRC_TBL0 = 2'd1,
    RSRC_TBL1 = 2'd2
  } rd_src_e;

endpackage

// File: rtl/lutdac_wen_gate.sv
module lutdac_wen_gate
  import lutdac_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic          wen_q,
  output logic          accept,
  output logic          wack_q
);

  logic hit_wen;

  assign hit_wen = (addr == AW'(ADDR_WEN));
  assign accept  = wr && (hit_wen || wen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q  <= 1'b0;
      wack_q <= 1'b0;
    end else begin
      wack_q <= accept;
      if (wr && hit_wen) begin
        if (wr_data == DW'(WEN_ARM))         wen_q <= 1'b1;
        else if (wr_data == DW'(WEN_DISARM)) wen_q <= 1'b0;
      end
    end
  end

  p_arm_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_wen && wr_data == DW'(WEN_ARM)) |=> wen_q);

  p_disarm_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_wen && wr_data == DW'(WEN_DISARM)) |=> !wen_q);

  p_flag_only_by_own_addr_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && hit_wen) |=> $stable(wen_q));

  p_blocked_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && !wen_q && !hit_wen) |=> !wack_q);

  p_odd_value_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_wen && wr_data != DW'(WEN_ARM) && wr_data != DW'(WEN_DISARM))
      |=> ($stable(wen_q) && wack_q));

  p_idle_no_ack_r6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> !wack_q);

endmodule

// File: rtl/lutdac_table.sv
module lutdac_table #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          bus_re,
  input  logic [IW-1:0] bus_idx,
  output logic [DW-1:0] bus_rdata,
  input  logic [IW-1:0] lk_idx,
  output logic [DW-1:0] lk_data
);

  localparam int unsigned DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (bus_re) bus_rdata <= mem[bus_idx];
  end

  assign lk_data = mem[lk_idx];

endmodule

// File: rtl/lutdac_channel.sv
module lutdac_channel #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          use_direct,
  input  logic          use_raw,
  input  logic [IW-1:0] adc_code,
  input  logic [IW-1:0] direct_idx,
  input  logic [DW-1:0] raw_code,
  output logic [IW-1:0] lk_idx,
  input  logic [DW-1:0] lk_data,
  output logic [DW-1:0] dac_q
);

  assign lk_idx = use_direct ? direct_idx : adc_code;

  always_ff @(posedge clk) begin
    if (rst) dac_q <= '0;
    else     dac_q <= use_raw ? raw_code : lk_data;
  end

  // R9 / R10: raw source reaches the DAC one edge later
  p_raw_path_r9: assert property (@(posedge clk) disable iff (rst)
    (use_raw && !$isunknown(raw_code)) |=> (dac_q == $past(raw_code)));

  // R11: index route, table path
  p_table_path_r11: assert property (@(posedge clk) disable iff (rst)
    (!use_raw && !$isunknown(lk_data)) |=> (dac_q == $past(lk_data)));

endmodule

// File: rtl/lutdac_regbank.sv
module lutdac_regbank
  import lutdac_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 8,
  parameter int unsigned IW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rd_data,
  output logic          wr_ack,
  input  logic [IW-1:0] adc_code,
  output logic [DW-1:0] dac1_code,
  output logic [DW-1:0] dac2_code
);

  localparam int unsigned NCH  = 2;
  localparam int unsigned WINW = AW - IW;

  logic          wen_q, accept;
  logic [3:0]    route_q;
  logic [IW-1:0] dir_q  [NCH];
  logic [DW-1:0] raw_q  [NCH];
  logic [DW-1:0] tbl_rd [NCH];
  logic [DW-1:0] dac_q  [NCH];
  logic [DW-1:0] reg_rd_q;
  rd_src_e       rsrc_q;

  lutdac_wen_gate #(.AW(AW), .DW(DW)) u_gate (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wr_data(wr_data),
    .wen_q(wen_q), .accept(accept), .wack_q(wr_ack)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          win_hit;
    logic [IW-1:0] lk_idx;
    logic [DW-1:0] lk_data;

    assign win_hit = (addr[AW-1:IW] == WINW'(c));

    lutdac_table #(.DW(DW), .IW(IW)) u_tbl (
      .clk(clk),
      .we(accept && win_hit),
      .widx(addr[IW-1:0]),
      .wdata(wr_data),
      .bus_re(rd && win_hit),
      .bus_idx(addr[IW-1:0]),
      .bus_rdata(tbl_rd[c]),
      .lk_idx(lk_idx),
      .lk_data(lk_data)
    );

    lutdac_channel #(.DW(DW), .IW(IW)) u_ch (
      .clk(clk), .rst(rst),
      .use_direct(route_q[2*c]),
      .use_raw(route_q[2*c+1]),
      .adc_code(adc_code),
      .direct_idx(dir_q[c]),
      .raw_code(raw_q[c]),
      .lk_idx(lk_idx),
      .lk_data(lk_data),
      .dac_q(dac_q[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q[c] <= '0;
        raw_q[c] <= '0;
      end else if (accept) begin
        if (addr == AW'(ADDR_DIR0) + AW'(c)) dir_q[c] <= wr_data[IW-1:0];
        if (addr == AW'(ADDR_RAW0) + AW'(c)) raw_q[c] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   route_q <= '0;
    else if (accept && addr == AW'(ADDR_ROUTE)) route_q <= wr_data[3:0];
  end

  // register-space read path; table reads come from the RAM output register
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rsrc_q   <= RSRC_REG;
    end else if (rd) begin
      reg_rd_q <= '0;
      if (addr[AW-1:IW] == WINW'(0))      rsrc_q <= RSRC_TBL0;
      else if (addr[AW-1:IW] == WINW'(1)) rsrc_q <= RSRC_TBL1;
      else                                rsrc_q <= RSRC_REG;
      unique case (addr)
        AW'(ADDR_ROUTE): reg_rd_q <= DW'(route_q);
        AW'(ADDR_WEN):   reg_rd_q <= {wen_q, {(DW-1){1'b0}}};
        AW'(ADDR_STAT):  reg_rd_q <= DW'(adc_code);
        default: begin
          for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(ADDR_DIR0) + AW'(c)) reg_rd_q <= DW'(dir_q[c]);
            if (addr == AW'(ADDR_RAW0) + AW'(c)) reg_rd_q <= raw_q[c];
          end
        end
      endcase
    end
  end

  always_comb begin
    unique case (rsrc_q)
      RSRC_TBL0: rd_data = tbl_rd[0];
      RSRC_TBL1: rd_data = tbl_rd[1];
      default:   rd_data = reg_rd_q;
    endcase
  end

  assign dac1_code = dac_q[0];
  assign dac2_code = dac_q[1];

  // R1: routing byte only changes through an accepted write
  p_route_guarded_r1: assert property (@(posedge clk) disable iff (rst)
    !(accept && addr == AW'(ADDR_ROUTE)) |=> $stable(route_q));

  // R5: the status address reads back the ADC code of the strobe cycle
  p_status_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == AW'(ADDR_STAT)) |=> (rd_data == DW'($past(adc_code))));

  // R3: raw codes stay put while writes are locked
  p_raw_locked_r3: assert property (@(posedge clk) disable iff (rst)
    !wen_q |=> ($stable(raw_q[0]) && $stable(raw_q[1])));

endmodule

// File: tb/lutdac_regbank_tb_top.sv
module lutdac_regbank_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rd_data;
  logic       wr_ack;
  logic [5:0] adc_code = '0;
  logic [7:0] dac1_code, dac2_code;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lutdac_regbank dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr(wr), .rd(rd),
    .rd_data(rd_data), .wr_ack(wr_ack), .adc_code(adc_code),
    .dac1_code(dac1_code), .dac2_code(dac2_code)
  );

  function automatic logic [7:0] t1v(int i);
    return 8'((i * 3) + 1);
  endfunction

  function automatic logic [7:0] t2v(int i);
    return 8'(8'hF0 - (i * 2));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one write; returns the acknowledge seen in the following cycle
  task automatic bus_wr(logic [7:0] a, logic [7:0] d, output logic ack);
    addr = a; wr_data = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    ack = wr_ack;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    d = rd_data;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R6 no ack at reset", {7'b0, wr_ack}, 8'h00);
    bus_rd(8'h86, d); chk("R1 flag clear", d, 8'h00);
    bus_rd(8'h80, d); chk("R1 routing zero", d, 8'h00);
    bus_rd(8'h83, d); chk("R1 raw1 zero", d, 8'h00);
    chk("R6 read gives no ack", {7'b0, wr_ack}, 8'h00);
  endtask

  task automatic t_locked();
    logic ack; logic [7:0] d;
    bus_wr(8'h81, 8'h15, ack); chk("R3 locked write ack", {7'b0, ack}, 8'h00);
    bus_rd(8'h81, d);          chk("R3 locked write no effect", d, 8'h00);
    bus_wr(8'h80, 8'h0F, ack); chk("R3 locked routing ack", {7'b0, ack}, 8'h00);
    bus_rd(8'h80, d);          chk("R3 routing unchanged", d, 8'h00);
  endtask

  task automatic t_odd_value();
    logic ack; logic [7:0] d;
    bus_wr(8'h86, 8'h55, ack); chk("R4 odd value ack", {7'b0, ack}, 8'h01);
    bus_rd(8'h86, d);          chk("R4 flag stays clear", d, 8'h00);
  endtask

  task automatic t_arm();
    logic ack; logic [7:0] d;
    bus_wr(8'h86, 8'h80, ack); chk("R2 arm ack", {7'b0, ack}, 8'h01);
    bus_rd(8'h86, d);          chk("R2 flag set", d, 8'h80);
    bus_wr(8'h86, 8'h7F, ack); chk("R4 odd value ack while set", {7'b0, ack}, 8'h01);
    bus_rd(8'h86, d);          chk("R4 flag stays set", d, 8'h80);
  endtask

  task automatic t_tables();
    logic ack; logic [7:0] d;
    for (int i = 0; i < 64; i++) begin
      bus_wr(8'(i), t1v(i), ack);
      bus_wr(8'(8'h40 + i), t2v(i), ack);
    end
    chk("R6 table write ack", {7'b0, ack}, 8'h01);
    bus_rd(8'h00, d); chk("R7 t1[0]", d, t1v(0));
    bus_rd(8'h3F, d); chk("R7 t1[63]", d, t1v(63));
    bus_rd(8'h40, d); chk("R7 t2[0]", d, t2v(0));
    bus_rd(8'h7F, d); chk("R7 t2[63]", d, t2v(63));
  endtask

  task automatic t_status();
    logic ack; logic [7:0] d;
    adc_code = 6'h2A;
    bus_rd(8'h87, d);          chk("R5 status read", d, 8'h2A);
    bus_wr(8'h87, 8'hFF, ack);
    bus_rd(8'h87, d);          chk("R5 status write dropped", d, 8'h2A);
    adc_code = 6'h3F;
    bus_rd(8'h87, d);          chk("R5 status full scale", d, 8'h3F);
  endtask

  task automatic t_adc_index();
    int pats [3] = '{0, 17, 63};
    foreach (pats[k]) begin
      adc_code = 6'(pats[k]);
      tick();
      chk("R8 dac1 adc indexed", dac1_code, t1v(pats[k]));
      chk("R10 dac2 adc indexed", dac2_code, t2v(pats[k]));
    end
  endtask

  task automatic t_direct1();
    logic ack; logic [7:0] d;
    adc_code = 6'd9;
    bus_wr(8'h81, 8'hC5, ack);
    bus_rd(8'h81, d);           chk("R8 direct index readback", d, 8'h05);
    bus_wr(8'h80, 8'h01, ack);
    tick();
    chk("R8 dac1 direct indexed", dac1_code, t1v(5));
    chk("R10 dac2 still adc", dac2_code, t2v(9));
  endtask

  task automatic t_raw1();
    logic ack;
    bus_wr(8'h83, 8'hA5, ack);
    bus_wr(8'h80, 8'h03, ack);
    tick();
    chk("R9 dac1 raw", dac1_code, 8'hA5);
    bus_wr(8'h83, 8'h5A, ack);
    chk("R11 dac1 not yet updated", dac1_code, 8'hA5);
    tick();
    chk("R11 dac1 one edge later", dac1_code, 8'h5A);
  endtask

  task automatic t_ch2();
    logic ack;
    bus_wr(8'h82, 8'h07, ack);
    bus_wr(8'h84, 8'h3C, ack);
    bus_wr(8'h80, 8'h07, ack);
    tick();
    chk("R10 dac2 direct", dac2_code, t2v(7));
    chk("R9 dac1 raw kept", dac1_code, 8'h5A);
    bus_wr(8'h80, 8'h0F, ack);
    tick();
    chk("R10 dac2 raw", dac2_code, 8'h3C);
  endtask

  task automatic t_disarm();
    logic ack; logic [7:0] d;
    bus_wr(8'h86, 8'h00, ack); chk("R2 disarm ack", {7'b0, ack}, 8'h01);
    bus_rd(8'h86, d);          chk("R2 flag cleared", d, 8'h00);
    bus_wr(8'h83, 8'h11, ack); chk("R3 locked raw ack", {7'b0, ack}, 8'h00);
    tick();
    chk("R3 dac1 unchanged", dac1_code, 8'h5A);
    bus_rd(8'h83, d);          chk("R3 raw1 unchanged", d, 8'h5A);
    bus_wr(8'h05, 8'hEE, ack); chk("R3 locked table ack", {7'b0, ack}, 8'h00);
    bus_rd(8'h05, d);          chk("R3 table unchanged", d, t1v(5));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_locked();
    t_odd_value();
    t_arm();
    t_tables();
    t_status();
    t_adc_index();
    t_direct1();
    t_raw1();
    t_ch2();
    t_disarm();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule